// File: doc/BRIEF.md
# Narrow-Result Width Predictor

This block guesses, early in the pipeline, whether an integer instruction will produce a result small enough to fit a narrow format. A result that fits can be sent over the fast, low-bandwidth result channel. Its dependents can then be woken early. The guess comes from a table of two-bit saturating counters, selected by the word-address bits of the instruction's PC.

At dispatch the lookup port takes a PC and returns a prediction in the same cycle. At writeback the update port takes the PC, the actual result value and the prediction that was made for that instruction. The entry is trained toward narrow or toward wide. If the instruction was predicted narrow but produced a wide value, a replay flag is raised for one cycle so that recovery logic can re-issue the dependents.

A narrow result is one that, read as a two's complement number, lies in the range of a signed 10-bit value. The table depth is a parameter. A depth of 8K entries needs 13 index bits.

Top module: `narrow_width_predictor`

## Requirements
- R1: After reset every counter holds 1. A lookup of any PC returns not-narrow and `replay` is low.
- R2: `lkNarrow` is 1 exactly when the counter selected by PC bits [IDX_BITS+1:2] holds 2 or 3. PC bits outside that field have no effect on which entry is selected.
- R3: An update with a narrow result increments the selected counter by one. The counter saturates at 3.
- R4: An update with a wide result decrements the selected counter by one. The counter saturates at 0.
- R5: A result is narrow when, read as a signed XLEN-bit value, it lies in [-512, 511]. With XLEN=32, 0x000001FF and 0xFFFFFE00 are narrow, while 0x00000200 and 0xFFFFFDFF are wide.
- R6: An update with `updPredNarrow`=1 and a wide result drives `replay` high in the following cycle, for that one cycle only.
- R7: An update with `updPredNarrow`=0, an update with a narrow result, or a cycle with no update leaves `replay` low in the following cycle.
- R8: When a lookup and an update hit the same entry in the same cycle, the lookup returns the value held before the write. The trained value is visible from the next cycle.
- R9: While `updValid` is low, no counter changes, whatever is on the other update inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkPc | input | XLEN | PC of the instruction being dispatched |
| lkNarrow | output | 1 | Prediction: 1 means the result is expected to be narrow |
| updValid | input | 1 | An update is presented this cycle |
| updPc | input | XLEN | PC of the instruction writing back |
| updValue | input | XLEN | Actual result value |
| updPredNarrow | input | 1 | Prediction that was given to this instruction |
| replay | output | 1 | One-cycle flag: a narrow prediction turned out wide |

## Verification
On every cycle, the assertions check the following:
- that the counter steps up or down by one and holds at its limits;
- that a counter is untouched when no update is presented;
- that `replay` only follows an update that carried a narrow prediction.

Only the bench's scenarios can show the other behaviours:
- that the correct entry is selected and aliasing works through the PC field;
- that the width threshold sits exactly at the signed 10-bit limits;
- that a same-cycle lookup sees the old counter;
- that prediction follows training history over long mixed sequences.

The bench's cycle-accurate model covers all of these.

// File: rtl/nwp_pkg.sv
package nwp_pkg;
  // strobes from the control to the counter table
  typedef struct packed {
    logic wrEn;   // write the selected counter this cycle
    logic incr;   // 1: step toward narrow, 0: step toward wide
  } nwpStrobes_t;

  localparam logic [1:0] CTR_RESET = 2'd1;
  localparam logic [1:0] CTR_MAX   = 2'd3;
  localparam logic [1:0] CTR_MIN   = 2'd0;
endpackage

// File: rtl/nwp_ctrl.sv
module nwp_ctrl
  import nwp_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int NARROW_BITS = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            updValid,
  input  logic [XLEN-1:0] updValue,
  input  logic            updPredNarrow,
  output nwpStrobes_t     strb,
  output logic            replay
);
  localparam int UPPER_W = XLEN - NARROW_BITS + 1;

  logic [UPPER_W-1:0] upperBits;
  logic               isNarrow;

  // narrow when the sign bit of the short field extends through the top
  assign upperBits = updValue[XLEN-1:NARROW_BITS-1];
  assign isNarrow  = (&upperBits) | ~(|upperBits);

  always_comb begin
    strb.wrEn = updValid;
    strb.incr = isNarrow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) replay <= 1'b0;
    else       replay <= updValid & updPredNarrow & ~isNarrow;
  end

  AST_REPLAY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(!updValid) |-> !replay)); // R7
endmodule

// File: rtl/nwp_datapath.sv
module nwp_datapath
  import nwp_pkg::*;
#(
  parameter int IDX_BITS = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [IDX_BITS-1:0] lkIdx,
  input  logic [IDX_BITS-1:0] wrIdx,
  input  nwpStrobes_t         strb,
  output logic                lkNarrow
);
  localparam int DEPTH = 1 << IDX_BITS;

  logic [1:0] ctrTable [DEPTH];
  logic [1:0] oldCtr;
  logic [1:0] nextCtr;

  assign oldCtr   = ctrTable[wrIdx];
  assign lkNarrow = ctrTable[lkIdx][1];

  always_comb begin
    if (strb.incr) nextCtr = (oldCtr == CTR_MAX) ? CTR_MAX : oldCtr + 2'd1;
    else           nextCtr = (oldCtr == CTR_MIN) ? CTR_MIN : oldCtr - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) ctrTable[i] <= CTR_RESET;
    end else if (strb.wrEn) begin
      ctrTable[wrIdx] <= nextCtr;
    end
  end

  AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.incr && oldCtr == CTR_MAX) |=> ctrTable[$past(wrIdx)] == CTR_MAX); // R3
  AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.incr && oldCtr == CTR_MIN) |=> ctrTable[$past(wrIdx)] == CTR_MIN); // R4
  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.incr && oldCtr != CTR_MAX) |=> ctrTable[$past(wrIdx)] == $past(oldCtr) + 2'd1); // R3
  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && !strb.incr && oldCtr != CTR_MIN) |=> ctrTable[$past(wrIdx)] == $past(oldCtr) - 2'd1); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrEn |=> ctrTable[$past(wrIdx)] == $past(oldCtr)); // R9
endmodule

// File: rtl/narrow_width_predictor.sv
module narrow_width_predictor
  import nwp_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int IDX_BITS    = 10,
  parameter int NARROW_BITS = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [XLEN-1:0] lkPc,
  output logic            lkNarrow,
  input  logic            updValid,
  input  logic [XLEN-1:0] updPc,
  input  logic [XLEN-1:0] updValue,
  input  logic            updPredNarrow,
  output logic            replay
);
  localparam int IDX_LO = 2;
  localparam int IDX_HI = IDX_LO + IDX_BITS - 1;

  nwpStrobes_t         strb;
  logic [IDX_BITS-1:0] lkIdx;
  logic [IDX_BITS-1:0] wrIdx;

  assign lkIdx = lkPc[IDX_HI:IDX_LO];
  assign wrIdx = updPc[IDX_HI:IDX_LO];

  nwp_ctrl #(.XLEN(XLEN), .NARROW_BITS(NARROW_BITS)) i_ctrl (
    .clk(clk), .rstN(rstN), .updValid(updValid), .updValue(updValue),
    .updPredNarrow(updPredNarrow), .strb(strb), .replay(replay)
  );

  nwp_datapath #(.IDX_BITS(IDX_BITS)) i_dp (
    .clk(clk), .rstN(rstN), .lkIdx(lkIdx), .wrIdx(wrIdx),
    .strb(strb), .lkNarrow(lkNarrow)
  );

  AST_REPLAY_SRC: assert property (@(posedge clk) disable iff (!rstN)
    replay |-> $past(updValid && updPredNarrow)); // R6
endmodule

// File: tb/test_narrow_width_predictor.sv
module test_narrow_width_predictor;
  localparam int XLEN = 32;
  localparam int IDX_BITS = 10;
  localparam int DEPTH = 1 << IDX_BITS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [XLEN-1:0] lkPc = '0, updPc = '0, updValue = '0;
  logic updValid = 1'b0, updPredNarrow = 1'b0;
  logic lkNarrow, replay;

  int checks = 0;
  int failures = 0;
  int model [DEPTH];
  logic expReplay = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  narrow_width_predictor #(.XLEN(XLEN), .IDX_BITS(IDX_BITS), .NARROW_BITS(10)) i_narrow_width_predictor (
    .clk(clk), .rstN(rstN), .lkPc(lkPc), .lkNarrow(lkNarrow),
    .updValid(updValid), .updPc(updPc), .updValue(updValue),
    .updPredNarrow(updPredNarrow), .replay(replay)
  );

  function automatic int idxOf(input logic [XLEN-1:0] pc);
    return int'((pc >> 2) & (DEPTH - 1));
  endfunction

  function automatic logic fitsNarrow(input logic [XLEN-1:0] v);
    return ($signed(v) >= -512) && ($signed(v) <= 511);
  endfunction

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // one cycle: drive, compare against the model, then advance the model
  task automatic step(input logic [XLEN-1:0] lp, input logic uv,
                      input logic [XLEN-1:0] upc, input logic [XLEN-1:0] uval,
                      input logic upn, input string tag);
    @(negedge clk);
    lkPc = lp; updValid = uv; updPc = upc; updValue = uval; updPredNarrow = upn;
    #1;
    check(lkNarrow, model[idxOf(lp)] >= 2, tag);
    check(replay, expReplay, expReplay ? "R6" : "R7");
    if (uv) begin
      logic n;
      n = fitsNarrow(uval);
      expReplay = upn & ~n;
      if (n) model[idxOf(upc)] = (model[idxOf(upc)] == 3) ? 3 : model[idxOf(upc)] + 1;
      else   model[idxOf(upc)] = (model[idxOf(upc)] == 0) ? 0 : model[idxOf(upc)] - 1;
    end else begin
      expReplay = 1'b0;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] pcA = 32'h0000_1040;
    logic [XLEN-1:0] pcB = 32'h0000_2208;
    for (int i = 0; i < DEPTH; i++) model[i] = 1;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    lkPc = pcA; #1;
    check(lkNarrow, 1'b0, "R1");
    check(replay, 1'b0, "R1");
    rstN = 1'b1;

    step(pcA, 0, 0, 0, 0, "R1");
    step(pcB, 0, 0, 0, 0, "R1");

    // R8: same-cycle lookup sees the old counter (1 -> 2)
    step(pcA, 1, pcA, 32'd5, 0, "R8");
    step(pcA, 0, 0, 0, 0, "R8");
    // R3: saturate at 3, then one wide keeps it narrow
    repeat (4) step(pcA, 1, pcA, 32'd7, 0, "R3");
    step(pcA, 1, pcA, 32'h0001_0000, 1, "R3");
    step(pcA, 0, 0, 0, 0, "R3");
    // R4: drive to 0, then one narrow leaves it not-narrow
    repeat (5) step(pcB, 1, pcB, 32'h8000_0000, 0, "R4");
    step(pcB, 1, pcB, 32'd1, 0, "R4");
    step(pcB, 0, 0, 0, 0, "R4");
    step(pcB, 1, pcB, 32'd1, 0, "R4");
    step(pcB, 0, 0, 0, 0, "R4");

    // R5: threshold values with a narrow prediction
    step(pcB, 1, pcA, 32'h0000_01FF, 1, "R5");
    step(pcB, 1, pcA, 32'hFFFF_FE00, 1, "R5");
    step(pcB, 1, pcA, 32'h0000_0200, 1, "R5");
    step(pcB, 1, pcA, 32'hFFFF_FDFF, 1, "R5");
    step(pcB, 0, 0, 0, 0, "R5");
    // R6: back-to-back mispredicts, then R7: predicted wide, narrow result
    step(pcB, 1, pcB, 32'h0000_4000, 1, "R6");
    step(pcB, 1, pcB, 32'h0000_4000, 1, "R6");
    step(pcB, 1, pcB, 32'd3, 0, "R7");
    step(pcB, 1, pcB, 32'h0000_4000, 0, "R7");
    step(pcB, 0, 0, 0, 0, "R7");

    // R9: update inputs busy but valid low
    repeat (4) step(pcA, 0, pcA, 32'h7FFF_FFFF, 1, "R9");
    step(pcA, 0, 0, 0, 0, "R9");

    // R2: aliasing through bits outside [IDX_BITS+1:2]
    step(pcA + 32'h0000_1000, 0, 0, 0, 0, "R2");
    step(pcA | 32'h0000_0003, 0, 0, 0, 0, "R2");
    step(pcA + 32'h00F0_0000, 0, 0, 0, 0, "R2");
    for (int k = 0; k < 3; k++) step(32'h0000_5040, 1, pcA + 32'h0000_5000, 32'hFFFF_0000, 0, "R2");
    step(pcA, 0, 0, 0, 0, "R2");

    // mixed traffic over a small PC pool
    for (int n = 0; n < 3000; n++) begin
      logic [XLEN-1:0] lp, up, uv;
      lp = ($urandom % 16) << 2;
      up = ($urandom % 16) << 2;
      uv = ($urandom % 2) ? ($urandom % 1024) - 512 : $urandom;
      step(lp, 1'($urandom % 4 != 0), up, uv, 1'($urandom % 2), "R2");
    end
    step(pcA, 0, 0, 0, 0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule